// File: doc/BRIEF.md
# Faulty-Switch Angular Locator

This block names the failed power switch of a three-phase converter once an open-circuit fault has been flagged elsewhere. On a detection pulse it watches one full mains cycle of current-vector samples. It keeps the stationary-frame pair (alpha, beta) of the sample whose vector length is smallest. It then maps the angle of that pair to the nearest of six ideal sector centres, one for each switch.

The angle at the moment of detection is too scattered to be useful. For that reason the block always waits out the full window and uses the point of minimum vector length instead. This adds about one mains period of latency and makes the location reliable. No arctangent is computed. The nearest centre is the one whose unit vector gives the largest dot product with (alpha, beta). The six cosine and sine values are fixed-point constants that are worked out when the design is elaborated.

A downstream controller takes the 3-bit switch code when the one-cycle done pulse appears and then reconfigures the drive.

Top module: `fault_sector_locator`

## Requirements
- R1: After reset, `done` is low and `sw_code` is 0.
- R2: A `det_pulse` seen while idle opens a search window of exactly WIN (default 200) cycles with `smp_vld` high. Only strobes in cycles after the pulse count, so a strobe in the same cycle as the pulse is not part of the window.
- R3: Cycles inside the window with `smp_vld` low are ignored. They neither advance the window nor change the stored minimum.
- R4: The stored pair is the alpha/beta of the windowed sample with the smallest `mag_in`. When magnitudes are equal, the earliest such sample is kept.
- R5: Switch codes and ideal centres are: 0 = phase A upper at 0; 1 = phase A lower at π; 2 = phase B upper at 2π/3; 3 = phase B lower at 5π/3; 4 = phase C upper at 4π/3; 5 = phase C lower at π/3. The reported code is the centre nearest to the angle of the stored pair.
- R6: Angular distance wraps around 2π. For example, an angle of 350° or 335° is reported as code 0 and not as code 3.
- R7: `done` is high for exactly one cycle, two cycles after the cycle that carried the final windowed strobe. `sw_code` takes its new value in that same cycle and holds it until the next result.
- R8: A `det_pulse` that arrives during the search or during the following classification cycle is ignored. Each accepted pulse yields exactly one `done`.
- R9: If several centres are equally near, including the case where the stored pair is (0, 0), the lowest code wins. A zero vector therefore gives code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe for alpha_in, beta_in and mag_in |
| det_pulse | input | 1 | Fault detection pulse from the detector |
| alpha_in | input | DW (16) | Signed alpha current component |
| beta_in | input | DW (16) | Signed beta current component |
| mag_in | input | MW (17) | Unsigned vector length of the same sample |
| sw_code | output | 3 | Located switch code (see R5) |
| done | output | 1 | One-cycle result pulse |

## Verification
The conditions hardest to reach from the ports are the edges of the window: a strobe that shares a cycle with the detection pulse, a second pulse that lands mid-search, and two samples with exactly equal minimal magnitude. The stimulus sets each of these up on purpose. A bait sample with a tiny magnitude rides on the pulse cycle, a pulse is injected at sample 100, and a later equal-magnitude sample points into a different sector. In every case a wrong rule shows up directly in the reported code or in the timing of `done`. Angles that straddle the 0/2π seam and a zero-length minimum cover the wrap and tie rules. Strobe gaps stretch the window in time without changing its sample count.

// File: rtl/lcz_pkg.sv
package lcz_pkg;

    typedef enum logic [1:0] {
        LOC_IDLE = 2'd0,
        LOC_SEEK = 2'd1,
        LOC_PICK = 2'd2
    } loc_state_e;

    localparam int N_SECTORS = 6;

    // integer square root, bitwise, for elaboration-time constants
    function automatic longint isqrt(input longint v);
        longint r;
        longint t;
        r = 0;
        for (int k = 31; k >= 0; k--) begin
            t = r | (longint'(1) << k);
            if (t * t <= v) r = t;
        end
        return r;
    endfunction

    // cosine of sector centre idx, scaled by 2^frac
    function automatic int unit_cos(input int idx, input int frac);
        longint s;
        s = longint'(1) << frac;
        case (idx)
            0:       return int'(s);
            1:       return int'(-s);
            2, 4:    return int'(-(s / 2));
            default: return int'(s / 2);
        endcase
    endfunction

    // sine of sector centre idx, scaled by 2^frac
    function automatic int unit_sin(input int idx, input int frac);
        longint s;
        longint h;
        s = longint'(1) << frac;
        h = isqrt((3 * s * s) / 4);
        case (idx)
            0, 1:    return 0;
            2, 5:    return int'(h);
            default: return int'(-h);
        endcase
    endfunction

endpackage

// File: rtl/lcz_min_keep.sv
module lcz_min_keep #(
    parameter int DW = 16,
    parameter int MW = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 take,
    input  logic signed [DW-1:0] alpha,
    input  logic signed [DW-1:0] beta,
    input  logic        [MW-1:0] mag,
    output logic signed [DW-1:0] best_alpha,
    output logic signed [DW-1:0] best_beta,
    output logic        [MW-1:0] best_mag,
    output logic                 have
);

    typedef struct packed {
        logic signed [DW-1:0] a;
        logic signed [DW-1:0] b;
        logic        [MW-1:0] m;
        logic                 have;
    } keep_t;

    keep_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (clear) begin
            k_d.have = 1'b0;
        end else if (take) begin
            if (!k_q.have || (mag < k_q.m)) begin
                k_d.a    = alpha;
                k_d.b    = beta;
                k_d.m    = mag;
            end
            k_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    assign best_alpha = k_q.a;
    assign best_beta  = k_q.b;
    assign best_mag   = k_q.m;
    assign have       = k_q.have;

    // R4
    min_not_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (have && !clear) |=> (best_mag <= $past(best_mag)));

    // R4
    tie_keeps_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && have && !clear && (mag == best_mag)) |=> ($stable(best_alpha) && $stable(best_beta)));

    // R4
    take_sets_have_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clear) |=> have);

endmodule

// File: rtl/lcz_sector_pick.sv
module lcz_sector_pick #(
    parameter int DW = 16,
    parameter int CW = 14
) (
    input  logic signed [DW-1:0] alpha,
    input  logic signed [DW-1:0] beta,
    output logic        [2:0]    code
);

    localparam int PW = DW + CW + 3;

    logic signed [PW-1:0] dot [lcz_pkg::N_SECTORS];

    for (genvar g = 0; g < lcz_pkg::N_SECTORS; g++) begin : g_dot
        localparam logic signed [CW+1:0] CC = (CW+2)'(lcz_pkg::unit_cos(g, CW));
        localparam logic signed [CW+1:0] SS = (CW+2)'(lcz_pkg::unit_sin(g, CW));
        assign dot[g] = PW'(alpha) * PW'(CC) + PW'(beta) * PW'(SS);
    end

    logic signed [PW-1:0] top_v;

    always_comb begin
        top_v = dot[0];
        code  = 3'd0;
        for (int i = 1; i < lcz_pkg::N_SECTORS; i++) begin
            if (dot[i] > top_v) begin
                top_v = dot[i];
                code  = 3'(i);
            end
        end
    end

endmodule

// File: rtl/fault_sector_locator.sv
module fault_sector_locator #(
    parameter int DW  = 16,
    parameter int MW  = 17,
    parameter int WIN = 200,
    parameter int CW  = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld,
    input  logic                 det_pulse,
    input  logic signed [DW-1:0] alpha_in,
    input  logic signed [DW-1:0] beta_in,
    input  logic        [MW-1:0] mag_in,
    output logic        [2:0]    sw_code,
    output logic                 done
);
    import lcz_pkg::*;

    localparam int CNTW = $clog2(WIN + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(WIN - 1);

    typedef struct packed {
        loc_state_e      st;
        logic [CNTW-1:0] cnt;
        logic [2:0]      code;
        logic            done;
    } top_t;

    top_t r_d, r_q;

    logic                 clear_w, take_w, have_w;
    logic signed [DW-1:0] best_a, best_b;
    logic        [MW-1:0] best_m;
    logic        [2:0]    pick_code;

    assign clear_w = (r_q.st == LOC_IDLE) && det_pulse;
    assign take_w  = (r_q.st == LOC_SEEK) && smp_vld;

    lcz_min_keep #(.DW(DW), .MW(MW)) u_keep (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_w),
        .take       (take_w),
        .alpha      (alpha_in),
        .beta       (beta_in),
        .mag        (mag_in),
        .best_alpha (best_a),
        .best_beta  (best_b),
        .best_mag   (best_m),
        .have       (have_w)
    );

    lcz_sector_pick #(.DW(DW), .CW(CW)) u_pick (
        .alpha (best_a),
        .beta  (best_b),
        .code  (pick_code)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            LOC_IDLE: begin
                if (det_pulse) begin
                    r_d.st  = LOC_SEEK;
                    r_d.cnt = '0;
                end
            end
            LOC_SEEK: begin
                if (smp_vld) begin
                    if (r_q.cnt == LAST) r_d.st = LOC_PICK;
                    else                 r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            LOC_PICK: begin
                r_d.code = pick_code;
                r_d.done = 1'b1;
                r_d.st   = LOC_IDLE;
            end
            default: r_d.st = LOC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= LOC_IDLE;
        end else begin
            r_q      <= r_d;
        end
    end

    assign sw_code = r_q.code;
    assign done    = r_q.done;

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(r_q.st == LOC_PICK));

    // R7
    code_moves_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_code != $past(sw_code)) |-> done);

    // R3
    gap_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == LOC_SEEK) && !smp_vld) |=> ((r_q.st == LOC_SEEK) && $stable(r_q.cnt)));

    // R8
    det_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == LOC_SEEK) && det_pulse && !(smp_vld && (r_q.cnt == LAST))) |=> (r_q.st == LOC_SEEK));

    // R2
    window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == LOC_SEEK) && smp_vld && (r_q.cnt == LAST)) |=> ((r_q.st == LOC_PICK) && have_w));

endmodule

// File: tb/fault_sector_locator_tb.sv
module fault_sector_locator_tb;

    localparam int DW  = 16;
    localparam int MW  = 17;
    localparam int WIN = 200;
    localparam real PI = 3.14159265358979;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_vld = 1'b0;
    logic                 det_pulse = 1'b0;
    logic signed [DW-1:0] alpha_in = '0;
    logic signed [DW-1:0] beta_in = '0;
    logic        [MW-1:0] mag_in = '0;
    logic        [2:0]    sw_code;
    logic                 done;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    fault_sector_locator #(.DW(DW), .MW(MW), .WIN(WIN), .CW(14)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .det_pulse(det_pulse),
        .alpha_in(alpha_in), .beta_in(beta_in), .mag_in(mag_in),
        .sw_code(sw_code), .done(done)
    );

    // nearest centre by true angle with wrap, lowest code on ties (R5, R6, R9)
    function automatic int ref_code(input int a, input int b);
        real ang, d, bestd;
        real ctr [6];
        int  res;
        ctr[0] = 0.0; ctr[1] = PI; ctr[2] = 2.0*PI/3.0;
        ctr[3] = 5.0*PI/3.0; ctr[4] = 4.0*PI/3.0; ctr[5] = PI/3.0;
        ang = $atan2(real'(b), real'(a));
        if (ang < 0.0) ang = ang + 2.0*PI;
        res = 0; bestd = 10.0;
        for (int i = 0; i < 6; i++) begin
            d = (ang > ctr[i]) ? ang - ctr[i] : ctr[i] - ang;
            if (d > PI) d = 2.0*PI - d;
            if (d < bestd - 1.0e-9) begin bestd = d; res = i; end
        end
        return res;
    endfunction

    // behavioural reference, advanced on every rising edge
    int m_busy, m_n, m_cls, m_have, m_best, m_a, m_b;
    int exp_done, exp_code;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            m_busy = 0; m_n = 0; m_cls = 0; m_have = 0; m_best = 0;
            m_a = 0; m_b = 0; exp_done = 0; exp_code = 0;
        end else if (m_cls != 0) begin
            exp_done = 1; exp_code = ref_code(m_a, m_b); m_cls = 0;
        end else begin
            exp_done = 0;
            if (m_busy != 0) begin
                if (smp_vld) begin
                    if (m_have == 0 || int'(mag_in) < m_best) begin
                        m_best = int'(mag_in); m_a = int'(alpha_in); m_b = int'(beta_in);
                    end
                    m_have = 1;
                    m_n = m_n + 1;
                    if (m_n == WIN) begin m_busy = 0; m_cls = 1; end
                end
            end else if (det_pulse) begin
                m_busy = 1; m_n = 0; m_have = 0;
            end
        end
    end

    // per-cycle comparison away from the active edge (R7 timing, R5 code)
    always @(negedge clk) begin
        if (rst_n) begin
            total = total + 1;
            if (int'(done) != exp_done) begin
                bad = bad + 1;
                $display("FAIL R7 done timing at cycle %0d: got %0d expected %0d", cyc, done, exp_done);
            end
            total = total + 1;
            if (int'(sw_code) != exp_code) begin
                bad = bad + 1;
                $display("FAIL R5 code vs model at cycle %0d: got %0d expected %0d", cyc, sw_code, exp_code);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int got, input int expv);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic drive(input bit v, input bit dp, input int a, input int b, input int m);
        @(negedge clk);
        smp_vld = v; det_pulse = dp;
        alpha_in = DW'(a); beta_in = DW'(b); mag_in = MW'(m);
    endtask

    task automatic idle_cycle();
        drive(1'b0, 1'b0, 0, 0, 0);
    endtask

    // runs one detection and window; returns nothing, checks result code
    // mode: 0 plain, 1 strobe gaps (R3), 2 mid-window pulse (R8),
    //       3 bait strobe on pulse cycle (R2), 4 equal-magnitude tie (R4)
    task automatic run_case(input real deg, input int mmin, input int expv,
                            input string tag, input int mode);
        int a, b, m, got, seen;
        real r;
        if (mode == 3) drive(1'b1, 1'b1, -3, 0, 3);
        else           drive(1'b0, 1'b1, 0, 0, 0);
        for (int i = 0; i < WIN; i++) begin
            if (mode == 1 && (i % 3) == 2) begin
                idle_cycle();
                idle_cycle();
            end
            if (i == 73) begin
                r = deg * PI / 180.0;
                a = int'(real'(mmin) * $cos(r));
                b = int'(real'(mmin) * $sin(r));
                m = mmin;
            end else if (mode == 4 && i == 150) begin
                r = 250.0 * PI / 180.0;
                a = int'(real'(mmin) * $cos(r));
                b = int'(real'(mmin) * $sin(r));
                m = mmin;
            end else begin
                r = real'(i * 7) * PI / 180.0;
                m = 900 + (i % 5);
                a = int'(real'(m) * $cos(r));
                b = int'(real'(m) * $sin(r));
            end
            drive(1'b1, (mode == 2 && i == 100), a, b, m);
        end
        idle_cycle();
        seen = 0; got = -1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done && seen == 0) begin seen = 1; got = int'(sw_code); end
        end
        check(seen == 1, {tag, " done seen"}, seen, 1);
        check(got == expv, tag, got, expv);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1
        check(done == 1'b0, "R1 done at reset", int'(done), 0);
        check(sw_code == 3'd0, "R1 code at reset", int'(sw_code), 0);
        rst_n = 1'b1;
        repeat (3) idle_cycle();
        check(done == 1'b0, "R1 done idle", int'(done), 0);

        // R5 one case per sector, offset from the centre
        run_case( 10.0, 200, 0, "R5 sector A upper", 0);
        run_case(185.0, 200, 1, "R5 sector A lower", 0);
        run_case(115.0, 200, 2, "R5 sector B upper", 0);
        run_case(295.0, 200, 3, "R5 sector B lower", 0);
        run_case(235.0, 200, 4, "R5 sector C upper", 0);
        run_case( 55.0, 200, 5, "R5 sector C lower", 0);
        // R6 wrap across 2pi
        run_case(350.0, 180, 0, "R6 wrap 350", 0);
        run_case(335.0, 180, 0, "R6 wrap 335", 0);
        // R3 strobe gaps
        run_case(140.0, 150, 2, "R3 gaps", 1);
        // R8 pulse mid-search
        run_case(200.0, 150, 1, "R8 pulse mid window", 2);
        // R2 strobe on the pulse cycle is not counted
        run_case(300.0, 150, 3, "R2 pulse-cycle bait", 3);
        // R4 tie: 100 deg first, 250 deg later at equal magnitude
        run_case(100.0, 150, 2, "R4 tie first wins", 4);
        // R9 zero vector minimum
        run_case(0.0, 0, 0, "R9 zero vector", 0);
        // R7 back-to-back: code holds after done
        repeat (5) idle_cycle();
        check(done == 1'b0, "R7 done low after result", int'(done), 0);
        check(sw_code == 3'd0, "R7 code held", int'(sw_code), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule